// File: doc/BRIEF.md
# Legacy Window Attribute Router

This block decides where a memory access in the old 640 KB to 1 MB address window is sent. Seven small attribute registers, each one byte wide, sit at configuration offsets 0x90 to 0x96. Together they give a read-enable and a write-enable bit to each of thirteen segments in the upper part of that window. An access arrives with an address, a read/write flag and an initiator code. One clock later the block reports whether the address fell in a mapped segment, and if so whether main memory claims the access or it goes to the PCI side.

Only accesses from the host processor look at the attribute bits. Graphics, PCI and hub-link initiators always get main memory when they hit a segment. Software programs the registers through a simple write strobe with an offset and data byte. Reads return the stored value with no wait.

Top module: `legacy_window_router`

## Requirements
- R1: After reset every attribute register reads 0x00.
- R2: Offsets 0x90..0x96 are writable. Offset 0x90 keeps only bits 5:4. Offsets 0x91..0x96 keep bits 5:4 and 1:0. All other bits read as zero whatever was written.
- R3: A write to an offset outside 0x90..0x96 changes no register, and a read there returns 0x00.
- R4: Segments follow a fixed map. 0xF0000..0xFFFFF uses bits 5:4 of offset 0x90. For k = 0..11, the 16 KB segment at 0xC0000 + k*0x4000 uses offset 0x91 + k/2: bits 1:0 when k is even, bits 5:4 when k is odd. In each 2-bit field the lower bit is the read enable and the upper bit is the write enable.
- R5: A host read (acc_init = 2'b00, acc_write = 0) of a mapped segment goes to main memory (rt_to_mem = 1) when its read enable is set. Otherwise it goes to PCI (rt_to_mem = 0).
- R6: A host write of a mapped segment goes to main memory when its write enable is set. Otherwise it goes to PCI. This does not depend on the read enable.
- R7: An access from any non-host initiator (2'b01 graphics, 2'b10 PCI, 2'b11 hub link) that hits a mapped segment always gives rt_to_mem = 1.
- R8: An address outside 0xC0000..0xFFFFF, including 0xA0000..0xBFFFF and anything at or above 1 MB, gives rt_hit = 0 and rt_to_mem = 0.
- R9: The result is registered. rt_valid, rt_hit and rt_to_mem appear one clock after the access is sampled. rt_valid is low in any cycle that follows a cycle with no access.
- R10: A register write takes effect for accesses sampled on the next clock edge and later. An access sampled on the same edge as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_offset | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored value at cfg_offset, reserved bits zero |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_init | input | 2 | Initiator: 00 host, 01 graphics, 10 PCI, 11 hub link |
| rt_valid | output | 1 | Routing result valid |
| rt_hit | output | 1 | Address fell in a mapped segment |
| rt_to_mem | output | 1 | 1 = main memory claims, 0 = forwarded to PCI |

## Verification
A configuration write and a routed access can land on the same clock edge. In that case the access must see the attribute value from before the write. The bench provokes this by driving a write that enables a segment and a host access to that segment in the same cycle. It then checks that this access goes to PCI and that the next access to the segment goes to main memory. Exhaustive sweeps over every segment's first and last byte, under several register patterns and all initiators, are judged against a bench model built from the segment map.

// File: rtl/lwr_pkg.sv
// Package: shared types for the legacy window attribute router.
// Assumes 2-bit initiator codes and a 2-bit attribute field per segment.
package lwr_pkg;
    typedef enum logic [1:0] {
        INIT_HOST = 2'b00,
        INIT_GFX  = 2'b01,
        INIT_PCI  = 2'b10,
        INIT_HUB  = 2'b11
    } init_t;

    typedef struct packed {
        logic we;   // write enable
        logic re;   // read enable
    } attr_t;

    localparam int unsigned NUM_SEG = 13;
    localparam int unsigned SEG_IDX_W = 4;
endpackage

// File: rtl/lwr_attr_bank.sv
// Module: lwr_attr_bank
// Holds the attribute registers. Writes are masked so reserved bits never
// store a one. Exposes one attribute field per segment.
// Assumes one write per cycle and a combinational read port.
module lwr_attr_bank
    import lwr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 7,
    parameter logic [7:0]  BASE_OFF = 8'h90
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [7:0]           offset,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output attr_t [NUM_SEG-1:0]  seg_attr
);
    localparam logic [7:0] MASK_FIRST = 8'h30;
    localparam logic [7:0] MASK_REST  = 8'h33;

    logic [7:0]          regs [NUM_REGS];
    logic [NUM_REGS-1:0] sel;

    // Offset match per register.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            sel[i] = (offset == BASE_OFF + 8'(i));
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_reg
            localparam logic [7:0] MASK = (gi == 0) ? MASK_FIRST : MASK_REST;
            // Store the masked write data on a matching write strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[gi] <= 8'h00;
                else if (wr_en && sel[gi])
                    regs[gi] <= wdata & MASK;
            end
        end
    endgenerate

    // Read mux: OR of the selected register, zero when nothing matches.
    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) rdata = rdata | regs[i];
        end
    end

    // Segment fan-out: the top 64 KB segment, then the 16 KB segments in ascending order.
    always_comb begin
        seg_attr[0] = attr_t'(regs[0][5:4]);
        for (int k = 0; k < NUM_SEG - 1; k++) begin
            if (k % 2 == 0)
                seg_attr[k+1] = attr_t'(regs[1 + k/2][1:0]);
            else
                seg_attr[k+1] = attr_t'(regs[1 + k/2][5:4]);
        end
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & 8'hCC) == 8'h00);  // R2

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (seg_attr == '0));  // R1

    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(|sel)) |=> $stable(seg_attr));  // R3
endmodule

// File: rtl/lwr_seg_decode.sv
// Module: lwr_seg_decode
// Maps a byte address to a segment index. Index 0 is the top 64 KB and
// 1..12 are the 16 KB segments from 0xC0000 upward.
// Assumes ADDR_W is wider than 20 bits. Purely combinational.
module lwr_seg_decode
    import lwr_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit,
    output logic [SEG_IDX_W-1:0] seg_idx
);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(32'h000C_0000);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(32'h000F_FFFF);

    // Range compare and index extraction.
    always_comb begin
        hit = (addr >= LO_ADDR) && (addr <= HI_ADDR);
        if (addr[17:16] == 2'b11)
            seg_idx = '0;
        else
            seg_idx = SEG_IDX_W'(addr[17:14]) + SEG_IDX_W'(1);
    end
endmodule

// File: rtl/lwr_route.sv
// Module: lwr_route
// Registers the routing result for one access. Host accesses follow the
// segment's read or write enable. Other initiators go to memory on a hit.
// Assumes attr is the field of the segment that the decoder selected.
module lwr_route
    import lwr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  acc_valid,
    input  logic  acc_write,
    input  init_t acc_init,
    input  logic  hit,
    input  attr_t attr,
    output logic  rt_valid,
    output logic  rt_hit,
    output logic  rt_to_mem
);
    logic enable;
    logic to_mem_d;

    // Pick the enable for the direction, then apply the initiator rule.
    always_comb begin
        enable   = acc_write ? attr.we : attr.re;
        to_mem_d = acc_valid && hit && ((acc_init != INIT_HOST) || enable);
    end

    // One-cycle result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid  <= 1'b0;
            rt_hit    <= 1'b0;
            rt_to_mem <= 1'b0;
        end else begin
            rt_valid  <= acc_valid;
            rt_hit    <= acc_valid && hit;
            rt_to_mem <= to_mem_d;
        end
    end

    AST_NONHOST_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && hit && acc_init != INIT_HOST) |=> (rt_hit && rt_to_mem));  // R7

    AST_NOHIT_NOROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !hit) |=> (!rt_hit && !rt_to_mem));  // R8

    AST_HOST_READ_RE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && hit && acc_init == INIT_HOST && !acc_write && !attr.re) |=> !rt_to_mem);  // R5

    AST_HOST_WRITE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && hit && acc_init == INIT_HOST && acc_write && attr.we) |=> rt_to_mem);  // R6

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rt_valid);  // R9
endmodule

// File: rtl/legacy_window_router.sv
// Module: legacy_window_router (top)
// Ties the attribute bank, address decoder and route register together.
// Assumes a single clock domain and synchronous active-low reset.
module legacy_window_router
    import lwr_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned NUM_REGS = 7,
    parameter logic [7:0]  BASE_OFF = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_offset,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic [1:0]        acc_init,
    output logic              rt_valid,
    output logic              rt_hit,
    output logic              rt_to_mem
);
    attr_t [NUM_SEG-1:0]  seg_attr;
    logic                 hit;
    logic [SEG_IDX_W-1:0] seg_idx;
    attr_t                cur_attr;

    lwr_attr_bank #(.NUM_REGS(NUM_REGS), .BASE_OFF(BASE_OFF)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .offset   (cfg_offset),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .seg_attr (seg_attr)
    );

    lwr_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (acc_addr),
        .hit     (hit),
        .seg_idx (seg_idx)
    );

    // Select the attribute field of the decoded segment.
    always_comb begin
        cur_attr = '0;
        for (int s = 0; s < NUM_SEG; s++) begin
            if (seg_idx == SEG_IDX_W'(s)) cur_attr = seg_attr[s];
        end
    end

    lwr_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_init  (init_t'(acc_init)),
        .hit       (hit),
        .attr      (cur_attr),
        .rt_valid  (rt_valid),
        .rt_hit    (rt_hit),
        .rt_to_mem (rt_to_mem)
    );

    AST_HIT_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (seg_idx < SEG_IDX_W'(NUM_SEG)));  // R4
endmodule

// File: tb/legacy_window_router_tb.sv
module legacy_window_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_offset = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_init = 2'b00;
    logic        rt_valid, rt_hit, rt_to_mem;

    int total = 0;
    int bad = 0;
    logic [7:0] model [7];

    always #2 clk = ~clk;

    legacy_window_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_offset(cfg_offset),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_init(acc_init),
        .rt_valid(rt_valid), .rt_hit(rt_hit), .rt_to_mem(rt_to_mem)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Expected hit and field from the segment map (R4).
    function automatic logic [2:0] expect_seg(logic [31:0] a);
        int k;
        if (a >= 32'hF0000 && a <= 32'hFFFFF) return {1'b1, model[0][5:4]};
        if (a >= 32'hC0000 && a <= 32'hEFFFF) begin
            k = int'((a - 32'hC0000) / 32'h4000);
            return (k % 2 == 0) ? {1'b1, model[1 + k/2][1:0]} : {1'b1, model[1 + k/2][5:4]};
        end
        return 3'b000;
    endfunction

    task automatic cfg_write(logic [7:0] off, logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_offset = off; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (off >= 8'h90 && off <= 8'h96)
            model[off - 8'h90] = d & ((off == 8'h90) ? 8'h30 : 8'h33);
    endtask

    task automatic cfg_read(string req, logic [7:0] off, logic [7:0] exp);
        cfg_offset = off;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
        @(negedge clk);
    endtask

    task automatic access(string req, logic [31:0] a, logic w, logic [1:0] ini);
        logic [2:0] s;
        logic exp_mem;
        s = expect_seg(a);
        exp_mem = s[2] && ((ini != 2'b00) || (w ? s[1] : s[0]));
        acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_init = ini;
        @(negedge clk);
        acc_valid = 1'b0;
        check(req, {29'h0, rt_valid, rt_hit, rt_to_mem}, {29'h0, 1'b1, s[2], exp_mem});
    endtask

    // R1: reset values.
    task automatic t_reset();
        for (int i = 0; i < 7; i++) cfg_read("R1", 8'h90 + 8'(i), 8'h00);
        check("R9 idle", {31'h0, rt_valid}, 32'h0);
    endtask

    // R2/R3: masking, out-of-range writes and reads.
    task automatic t_regs();
        for (int i = 0; i < 7; i++) cfg_write(8'h90 + 8'(i), 8'hFF);
        for (int i = 0; i < 7; i++) cfg_read("R2", 8'h90 + 8'(i), i == 0 ? 8'h30 : 8'h33);
        cfg_write(8'h97, 8'h00);
        cfg_write(8'h8F, 8'h00);
        for (int i = 0; i < 7; i++) cfg_read("R3 unchanged", 8'h90 + 8'(i), model[i]);
        cfg_read("R3 read", 8'h97, 8'h00);
        cfg_read("R3 read", 8'h8F, 8'h00);
        access("R3 route", 32'hC0000, 1'b0, 2'b00);
    endtask

    // R4-R7: sweep all segments and initiators for one register pattern.
    task automatic t_sweep(int seed);
        for (int i = 0; i < 7; i++)
            cfg_write(8'h90 + 8'(i), 8'((i * 37 + seed * 91) ^ (seed << 4)));
        for (int k = 0; k < 13; k++) begin
            logic [31:0] base;
            base = (k == 12) ? 32'hF0000 : 32'hC0000 + 32'(k) * 32'h4000;
            for (int ini = 0; ini < 4; ini++) begin
                access(ini == 0 ? "R4 R5 host rd" : "R7 rd", base, 1'b0, 2'(ini));
                access(ini == 0 ? "R4 R6 host wr" : "R7 wr",
                       base + ((k == 12) ? 32'hFFFF : 32'h3FFF), 1'b1, 2'(ini));
            end
        end
    endtask

    // R5/R6: read-only and write-only combinations on one segment.
    task automatic t_modes();
        cfg_write(8'h91, 8'h21);
        access("R5 ro rd", 32'hC0000, 1'b0, 2'b00);
        access("R6 ro wr", 32'hC0000, 1'b1, 2'b00);
        access("R5 wo rd", 32'hC4000, 1'b0, 2'b00);
        access("R6 wo wr", 32'hC4000, 1'b1, 2'b00);
        cfg_write(8'h91, 8'h00);
        access("R5 off rd", 32'hC0000, 1'b0, 2'b00);
        access("R6 off wr", 32'hC4000, 1'b1, 2'b00);
    endtask

    // R8: addresses outside the mapped segments.
    task automatic t_outside();
        logic [31:0] list [6];
        list = '{32'h9FFFF, 32'hA0000, 32'hBFFFF, 32'h100000, 32'hFFFFFFFF, 32'h1C0000};
        foreach (list[i]) begin
            access("R8", list[i], 1'b0, 2'b00);
            access("R8", list[i], 1'b1, 2'b10);
        end
    endtask

    // R9/R10: latency and a write landing with an access in the same cycle.
    task automatic t_same_cycle();
        cfg_write(8'h94, 8'h00);
        cfg_wr_en = 1'b1; cfg_offset = 8'h94; cfg_wdata = 8'h03;
        acc_valid = 1'b1; acc_addr = 32'hD8000; acc_write = 1'b0; acc_init = 2'b00;
        @(negedge clk);
        cfg_wr_en = 1'b0; acc_valid = 1'b0;
        model[4] = 8'h03;
        check("R10 old value", {29'h0, rt_valid, rt_hit, rt_to_mem}, 32'h6);
        @(negedge clk);
        check("R9 drop", {31'h0, rt_valid}, 32'h0);
        access("R10 new value", 32'hD8000, 1'b0, 2'b00);
        access("R10 new value wr", 32'hDBFFF, 1'b1, 2'b00);
    endtask

    initial begin
        for (int i = 0; i < 7; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_modes();
        for (int s = 0; s < 3; s++) t_sweep(s);
        t_outside();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule